// File: doc/BRIEF.md
# Half-Precision Floating-Point Adder-Subtractor

This unit adds or subtracts two 16-bit floating-point numbers. The format has 1 sign bit, a 5-bit exponent with bias 15, and a 10-bit fraction behind an implied leading one. The work is split over two register stages:

- **Stage one** sanitizes both operands and orders them by magnitude. It aligns the smaller one with a logarithmic right shifter that collects a sticky bit as it goes, then adds or subtracts the magnitudes. Subtraction is done as an add of the inverted operand with a carry-in of one.
- **Stage two** normalizes the raw sum with a leading-zero count and a left barrel shifter. It then rounds to nearest even and packs the result.

The unit is meant for a streaming datapath. A caller may present one operation per cycle, qualified by `in_valid`, and collects each result two cycles later under `out_valid`. There are no exception flags. Special inputs are folded into ordinary numbers, and results outside the normal range are clamped or flushed, so the output is always a normal number or +0.

Top module: `fp16_addsub`

## Requirements
- R1: With `op_sub` low and both operands normal, `result` is the sum a + b rounded to the nearest representable value (e.g. 0x3C00 + 0x4000 gives 0x4200).
- R2: With `op_sub` high, `result` is a − b with the same rounding, including heavy cancellation (0x3C00 − 0x3BFF gives 0x1000).
- R3: The effective operation comes from sign(a) XOR sign(b) XOR `op_sub`. The result takes the sign of the operand of larger magnitude (0x3C00 − 0x4200 gives 0xC000).
- R4: A value exactly halfway between two neighbours rounds to the one with an even fraction LSB (0x6800 + 0x3C00 gives 0x6800; 0x6801 + 0x3C00 gives 0x6802).
- R5: When rounding carries out of the 11-bit significand, the fraction becomes zero and the exponent rises by one (0x3FFF + 0x1000 gives 0x4000).
- R6: When the exponent difference is 13 or more, the smaller operand enters only the sticky bit (0x6800 + 0x3400 gives 0x6800; 0x4000 − 0x0C00 gives 0x4000).
- R7: An exact zero result is always +0, i.e. 0x0000.
- R8: A result whose exponent would reach 31, including by rounding, saturates to ±65504 (0x7BFF / 0xFBFF). The exponent field of `result` is never 31.
- R9: A result whose exponent would be 0 or below is flushed to 0x0000. No subnormal value is ever produced.
- R10: An operand with exponent field 0 is treated as zero, whatever its fraction.
- R11: An operand with exponent field 31 (infinity or NaN) is treated as the largest finite value of its own sign.
- R12: A request accepted with `in_valid` high yields `out_valid` high with its result exactly two clock cycles later. Without a request, `out_valid` is low two cycles later.
- R13: While `rst_n` is low, `out_valid` and `result` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and `op_sub` are valid this cycle |
| op_a | input | 16 | Operand a |
| op_b | input | 16 | Operand b |
| op_sub | input | 1 | 0: a + b, 1: a − b |
| out_valid | output | 1 | `result` holds the outcome of the request from two cycles earlier |
| result | output | 16 | Rounded sum or difference |

## Verification
The hardest cases to reach are those where the three rounding bits left after normalization decide the result. Examples are an exact tie, a tie that carries out of the significand, and a subtraction whose only contribution from the small operand is the sticky bit, so the borrow must ripple through the whole significand.

These cases only arise at specific exponent distances. The vector table therefore picks operand pairs 11, 12 and 13 exponent steps apart, and pairs one unit apart with opposite effective signs. This drives the guard, round and sticky positions and the leading-zero shifter deliberately, rather than hoping random values reach them.

// File: rtl/fp16_pkg.sv
package fp16_pkg;
    localparam int EXP_W   = 5;
    localparam int FRAC_W  = 10;
    localparam int WORD_W  = 1 + EXP_W + FRAC_W;
    localparam int MAN_W   = FRAC_W + 1;          // with implied one
    localparam int EXT_W   = MAN_W + 3;           // plus guard, round, sticky
    localparam int SH_W    = $clog2(EXT_W);       // alignment shift amount width
    localparam int LZ_W    = $clog2(EXT_W) + 1;   // leading-zero count width
    localparam int EXP_TOP = (1 << EXP_W) - 1;    // reserved exponent code
    localparam int FAR_GAP = EXT_W - 1;           // distance where only sticky survives

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } fp_word_t;
endpackage

// File: rtl/fp16_align.sv
module fp16_align
    import fp16_pkg::*;
#(
    parameter int W   = EXT_W,
    parameter int SHW = SH_W
) (
    input  logic [W-1:0]   din,
    input  logic [SHW-1:0] shamt,
    input  logic           far,
    output logic [W-1:0]   dout
);
    logic [W-1:0] stage_v [SHW+1];
    logic         stage_s [SHW+1];

    assign stage_v[0] = din;
    assign stage_s[0] = 1'b0;

    for (genvar k = 0; k < SHW; k++) begin : g_stage
        localparam int STEP = 1 << k;
        always_comb begin
            if (shamt[k]) begin
                stage_v[k+1] = stage_v[k] >> STEP;
                stage_s[k+1] = stage_s[k] | (|stage_v[k][STEP-1:0]);
            end else begin
                stage_v[k+1] = stage_v[k];
                stage_s[k+1] = stage_s[k];
            end
        end
    end

    always_comb begin
        if (far) begin
            dout = {{(W-1){1'b0}}, |din};
        end else begin
            dout = stage_v[SHW];
            dout[0] = stage_v[SHW][0] | stage_s[SHW];
        end
    end
endmodule

// File: rtl/fp16_norm.sv
module fp16_norm
    import fp16_pkg::*;
#(
    parameter int W   = EXT_W,
    parameter int LZW = LZ_W
) (
    input  logic [W:0]     sum,
    output logic [W-1:0]   mant,
    output logic [LZW-1:0] lz,
    output logic           carry
);
    logic [W-1:0] body;
    logic [W-1:0] sh_v [LZW+1];

    assign body  = sum[W-1:0];
    assign carry = sum[W];

    always_comb begin
        lz = '0;
        for (int i = 0; i < W; i++) begin
            if (body[i]) lz = LZW'(W - 1 - i);
        end
    end

    assign sh_v[0] = body;
    for (genvar k = 0; k < LZW; k++) begin : g_shift
        assign sh_v[k+1] = lz[k] ? (sh_v[k] << (1 << k)) : sh_v[k];
    end

    always_comb begin
        if (carry) mant = {sum[W:2], sum[1] | sum[0]};
        else       mant = sh_v[LZW];
    end
endmodule

// File: rtl/fp16_round.sv
module fp16_round
    import fp16_pkg::*;
#(
    parameter int W  = EXT_W,
    parameter int FW = FRAC_W
) (
    input  logic [W-1:0]  mant,
    output logic [FW-1:0] frac,
    output logic          carry
);
    logic       lsb, grd, rnd, stk, up;
    logic [W-3:0] rounded;

    assign lsb = mant[3];
    assign grd = mant[2];
    assign rnd = mant[1];
    assign stk = mant[0];
    assign up  = grd & (rnd | stk | lsb);

    assign rounded = {1'b0, mant[W-1:3]} + {{(W-3){1'b0}}, up};
    assign carry   = rounded[W-3];
    assign frac    = rounded[FW-1:0];
endmodule

// File: rtl/fp16_addsub.sv
module fp16_addsub
    import fp16_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic              op_sub,
    output logic              out_valid,
    output logic [WORD_W-1:0] result
);
    localparam int XW = EXP_W + 2;   // signed exponent working width

    typedef struct packed {
        logic              v1;
        logic              sign1;
        logic [EXP_W-1:0]  exp1;
        logic [EXT_W:0]    sum1;
        logic              v2;
        logic [WORD_W-1:0] res2;
    } pipe_t;

    pipe_t st_d, st_q;

    function automatic fp_word_t sanitize(input logic [WORD_W-1:0] w);
        fp_word_t f;
        f = w;
        if (f.exp == '0) begin
            f.frac = '0;
        end else if (f.exp == EXP_W'(EXP_TOP)) begin
            f.exp  = EXP_W'(EXP_TOP - 1);
            f.frac = '1;
        end
        return f;
    endfunction

    // stage one signals
    fp_word_t         fa, fb, big, sml;
    logic             sgn_a, sgn_b, a_big, eff_sub, big_sign, far;
    logic [EXP_W-1:0] gap;
    logic [EXT_W-1:0] big_ext, sml_ext, sml_al;
    logic [EXT_W:0]   addend, raw_sum;

    always_comb begin
        fa       = sanitize(op_a);
        fb       = sanitize(op_b);
        sgn_a    = fa.sign;
        sgn_b    = fb.sign ^ op_sub;
        eff_sub  = sgn_a ^ sgn_b;
        a_big    = {fa.exp, fa.frac} >= {fb.exp, fb.frac};
        big      = a_big ? fa : fb;
        sml      = a_big ? fb : fa;
        big_sign = a_big ? sgn_a : sgn_b;
        gap      = big.exp - sml.exp;
        far      = gap >= EXP_W'(FAR_GAP);
        big_ext  = {|big.exp, big.frac, 3'b000};
        sml_ext  = {|sml.exp, sml.frac, 3'b000};
    end

    fp16_align #(.W(EXT_W), .SHW(SH_W)) u_align (
        .din   (sml_ext),
        .shamt (gap[SH_W-1:0]),
        .far   (far),
        .dout  (sml_al)
    );

    always_comb begin
        addend  = eff_sub ? ~{1'b0, sml_al} : {1'b0, sml_al};
        raw_sum = {1'b0, big_ext} + addend + {{EXT_W{1'b0}}, eff_sub};
    end

    // stage two signals
    logic [EXT_W-1:0]  n_mant;
    logic [LZ_W-1:0]   n_lz;
    logic              n_carry, r_carry;
    logic [FRAC_W-1:0] r_frac;
    logic signed [XW-1:0] e_fin;

    fp16_norm #(.W(EXT_W), .LZW(LZ_W)) u_norm (
        .sum   (st_q.sum1),
        .mant  (n_mant),
        .lz    (n_lz),
        .carry (n_carry)
    );

    fp16_round #(.W(EXT_W), .FW(FRAC_W)) u_round (
        .mant  (n_mant),
        .frac  (r_frac),
        .carry (r_carry)
    );

    always_comb begin
        st_d = st_q;
        // stage one capture
        st_d.v1    = in_valid;
        st_d.sign1 = big_sign;
        st_d.exp1  = big.exp;
        st_d.sum1  = raw_sum;
        // stage two: exponent adjust, range handling, packing
        e_fin = $signed({2'b00, st_q.exp1})
              + (n_carry ? XW'(1) : -$signed({{(XW-LZ_W){1'b0}}, n_lz}))
              + XW'(r_carry);
        st_d.v2 = st_q.v1;
        if (st_q.sum1 == '0 || e_fin <= 0) begin
            st_d.res2 = '0;
        end else if (e_fin >= XW'(EXP_TOP)) begin
            st_d.res2 = {st_q.sign1, EXP_W'(EXP_TOP - 1), {FRAC_W{1'b1}}};
        end else begin
            st_d.res2 = {st_q.sign1, e_fin[EXP_W-1:0], r_frac};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.v2;
    assign result    = st_q.res2;
endmodule

// File: rtl/fp16_addsub_chk.sv
module fp16_addsub_chk
    import fp16_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              out_valid,
    input logic [WORD_W-1:0] result
);
    // R12
    lat_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    // R12
    lat_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);

    // R8
    no_top_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> result[WORD_W-2 -: EXP_W] != '1);

    // R9
    no_subnormal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && result[WORD_W-2 -: EXP_W] == '0) |-> result[FRAC_W-1:0] == '0);

    // R7
    plus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && result[WORD_W-2:0] == '0) |-> !result[WORD_W-1]);

    // R13
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0));
endmodule

bind fp16_addsub fp16_addsub_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/fp16_addsub_tb.sv
module fp16_addsub_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic        op_sub = 1'b0;
    logic        out_valid;
    logic [15:0] result;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    fp16_addsub u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .op_sub(op_sub),
        .out_valid(out_valid), .result(result)
    );

    typedef struct packed {
        logic [15:0] tag;
        logic [15:0] a;
        logic [15:0] b;
        logic        sub;
        logic [15:0] want;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{"R1", 16'h3C00, 16'h3C00, 1'b0, 16'h4000},
        '{"R1", 16'h3C00, 16'h4000, 1'b0, 16'h4200},
        '{"R1", 16'h3E00, 16'h3800, 1'b0, 16'h4000},
        '{"R1", 16'h6800, 16'h3E00, 1'b0, 16'h6801},
        '{"R2", 16'h4200, 16'h3C00, 1'b1, 16'h4000},
        '{"R2", 16'h3C00, 16'h3BFF, 1'b1, 16'h1000},
        '{"R3", 16'h3C00, 16'h4200, 1'b1, 16'hC000},
        '{"R3", 16'hBC00, 16'hC000, 1'b0, 16'hC200},
        '{"R7", 16'h3C00, 16'h3C00, 1'b1, 16'h0000},
        '{"R7", 16'hBC00, 16'h3C00, 1'b0, 16'h0000},
        '{"R4", 16'h6800, 16'h3C00, 1'b0, 16'h6800},
        '{"R4", 16'h6801, 16'h3C00, 1'b0, 16'h6802},
        '{"R5", 16'h3FFF, 16'h1000, 1'b0, 16'h4000},
        '{"R5", 16'h4000, 16'h1000, 1'b1, 16'h4000},
        '{"R6", 16'h6800, 16'h3400, 1'b0, 16'h6800},
        '{"R6", 16'h6800, 16'h3400, 1'b1, 16'h6800},
        '{"R6", 16'h4000, 16'h0C00, 1'b1, 16'h4000},
        '{"R8", 16'h7BFF, 16'h7BFF, 1'b0, 16'h7BFF},
        '{"R8", 16'h7BFF, 16'h4C00, 1'b0, 16'h7BFF},
        '{"R8", 16'hFBFF, 16'hFBFF, 1'b0, 16'hFBFF},
        '{"R9", 16'h0600, 16'h0400, 1'b1, 16'h0000},
        '{"R10", 16'h0001, 16'h3C00, 1'b0, 16'h3C00},
        '{"R11", 16'h7C00, 16'h0000, 1'b0, 16'h7BFF},
        '{"R11", 16'hFE00, 16'h0000, 1'b1, 16'hFBFF}
    };

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic run_op(input string req, input logic [15:0] a, input logic [15:0] b,
                          input logic s, input logic [15:0] want);
        @(negedge clk);
        op_a = a; op_b = b; op_sub = s; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check("R12 valid", {15'd0, out_valid}, 16'd1);
        check(req, result, want);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R13: reset state
        check("R13 valid", {15'd0, out_valid}, 16'd0);
        check("R13 result", result, 16'h0000);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run_op($sformatf("%s", VECS[i].tag), VECS[i].a, VECS[i].b, VECS[i].sub, VECS[i].want);
        end

        // R10: subnormal operands act as zero, opposite signs
        run_op("R10", 16'h03FF, 16'h83FF, 1'b0, 16'h0000);
        // R3: operand order does not change the sum
        run_op("R3", 16'h4000, 16'h3C00, 1'b0, 16'h4200);

        // R12: no request gives no valid two cycles on
        @(negedge clk);
        @(negedge clk);
        check("R12 idle", {15'd0, out_valid}, 16'd0);

        // R12: back-to-back requests stream one per cycle
        @(negedge clk);
        op_a = 16'h3C00; op_b = 16'h3C00; op_sub = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        op_a = 16'h4200; op_b = 16'h3C00; op_sub = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R12 first", result, 16'h4000);
        @(negedge clk);
        check("R12 second", result, 16'h4000);
        check("R12 second valid", {15'd0, out_valid}, 16'd1);

        // R13: reset applied mid-run clears outputs
        @(negedge clk);
        op_a = 16'h3C00; op_b = 16'h4000; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R13 mid valid", {15'd0, out_valid}, 16'd0);
        check("R13 mid result", result, 16'h0000);

        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end
endmodule